// File: doc/BRIEF.md
# Line-locked pixel clock divider and phase comparator

This block is the synchronous heart of a horizontal-sync genlock loop. It runs on the recovered pixel clock and divides it by a line length N. N comes from one of eight fixed video line lengths, picked by a 3-bit code. The block compares the divided wrap pulse with the rising edge of the incoming horizontal sync. From that comparison it issues raise and lower requests to an external charge pump, together with a pump-enable that stands in for the pump's high-impedance state.

The internal divider can be switched out. An externally divided pulse then acts as the feedback edge, and the divided-clock output stays quiet. A decoded 2-bit mode chooses one of three behaviours. Normal mode lets the divider run freely. Fast-lock mode snaps the divider to each sync edge until lock is reached. Coast mode silences the pump. The block declares lock after a run of well-aligned lines. A lock-fail flag goes high for one line length after every misaligned line.

Top module: `hsync_lock_core`

## Requirements
- R1: With `int_div_i` high, `div_o` is a one-clock pulse every N clocks, where `prog_i` selects N: 3'b000→1702, 3'b001→1728, 3'b010→1888, 3'b011→2270, 3'b100→1364, 3'b101→1716, 3'b110→1560, 3'b111→1820.
- R2: With `int_div_i` low, the internal divider is stopped and `div_o` stays low. Rising edges of `ext_div_i` are used as the feedback edge in its place.
- R3: `hsync_i` passes through a two-flop synchronizer, and only its rising edge is used. A sync pulse that stays high for several clocks counts as a single edge.
- R4: When the sync edge arrives before the feedback edge, `pump_up_o` is high from the sync edge until the feedback edge. A sync period shorter than N therefore yields raise requests only.
- R5: When the feedback edge arrives before the sync edge, `pump_dn_o` is high from the feedback edge until the sync edge. A sync period longer than N therefore yields lower requests only.
- R6: A line counts as a hit when the two edges fall within WINDOW (default 2) clocks of each other. `locked_o` rises after LOCK_LINES (default 4) consecutive hits.
- R7: Any miss clears `locked_o` at once and restarts the hit count. `lock_fail_o` stays high until N clocks after the most recent miss, so two misses one line apart hold it high for 2N clocks.
- R8: `pump_en_o` is low whenever `locked_o` is high or `mode_i` is 2'b10 or 2'b11 (coast). While it is low, `pump_up_o` and `pump_dn_o` are both low.
- R9: With `mode_i` = 2'b01 (fast lock), the internal divider reloads to zero on each sync edge while unlocked, so a sync train at period N locks within LOCK_LINES+2 lines. With `mode_i` = 2'b00 (normal), the divider is never reloaded, and a misaligned sync train never locks.
- R10: If one edge stays unanswered for N clocks, that line is scored as a miss.
- R11: After reset, `locked_o`, `lock_fail_o`, `pump_up_o`, `pump_dn_o` and `div_o` are low, and `pump_en_o` is high in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| prog_i | input | 3 | Line-length select code |
| int_div_i | input | 1 | 1: internal divider, 0: external feedback |
| ext_div_i | input | 1 | Externally divided feedback pulse |
| mode_i | input | 2 | 00 normal, 01 fast lock, 1x coast |
| div_o | output | 1 | Internal divider wrap pulse |
| pump_up_o | output | 1 | Raise-frequency request |
| pump_dn_o | output | 1 | Lower-frequency request |
| pump_en_o | output | 1 | Pump drive enable (low means high impedance) |
| locked_o | output | 1 | Loop locked |
| lock_fail_o | output | 1 | High for a line after each miss |

## Verification
The bench builds the block with its default parameters: a lock run of 4 lines and a ±2-clock window. These defaults keep a relock, an injected late line and the two-miss fail stretch within a few thousand cycles each. Most scenarios use code 3'b100 (1364 clocks), the shortest line, which leaves room for about fifty lines. The divisor scenario also measures 3'b000 and 3'b011, the longest length, so the full counter width is exercised. The ±14-clock period offsets (about 1%) push the alignment error outside the window within one line, while the error stays well short of a line over the observed span.

// File: rtl/hlock_pkg.sv
package hlock_pkg;
  localparam int CNT_W = 12;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_FAST   = 2'b01,
    MODE_COAST  = 2'b10,
    MODE_COAST2 = 2'b11
  } mode_e;

  function automatic logic [CNT_W-1:0] line_len(input logic [2:0] code);
    case (code)
      3'b000:  line_len = CNT_W'(1702);
      3'b001:  line_len = CNT_W'(1728);
      3'b010:  line_len = CNT_W'(1888);
      3'b011:  line_len = CNT_W'(2270);
      3'b100:  line_len = CNT_W'(1364);
      3'b101:  line_len = CNT_W'(1716);
      3'b110:  line_len = CNT_W'(1560);
      default: line_len = CNT_W'(1820);
    endcase
  endfunction
endpackage

// File: rtl/hlock_line_div.sv
module hlock_line_div
  import hlock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q >= len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || reload_i || wrap_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1: wrap is always a single-clock pulse
  a_r1_single_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
endmodule

// File: rtl/hlock_pfd.sv
module hlock_pfd
  import hlock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             settle_o,
  output logic [CNT_W-1:0] err_o
);
  logic             up_q, dn_q;
  logic [CNT_W-1:0] err_q;
  logic             pend, up_n, dn_n, both, tmo;

  assign pend     = up_q | dn_q;
  assign up_n     = up_q | ref_i;
  assign dn_n     = dn_q | fb_i;
  assign both     = up_n & dn_n;
  assign tmo      = pend && !both && (err_q >= lim_i);  // unanswered for a line
  assign settle_o = both | tmo;
  assign err_o    = pend ? err_q : '0;
  assign up_o     = up_q;
  assign dn_o     = dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      err_q <= '0;
    end else if (settle_o) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      err_q <= '0;
    end else begin
      up_q  <= up_n;
      dn_q  <= dn_n;
      if (pend)             err_q <= (&err_q) ? err_q : err_q + CNT_W'(1);
      else if (up_n | dn_n) err_q <= CNT_W'(1);
    end
  end

  // R4, R5: raise and lower requests never overlap
  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_q && dn_q));
  // R10: a settled line leaves no pending request
  a_r10_settle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_o |=> !up_q && !dn_q);
endmodule

// File: rtl/hlock_lock_track.sv
module hlock_lock_track
  import hlock_pkg::*;
#(
  parameter int LOCK_LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             settle_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             locked_o,
  output logic             fail_o
);
  localparam int GW = $clog2(LOCK_LINES + 1);

  logic [GW-1:0]    good_q;
  logic [CNT_W-1:0] fail_q;
  logic             locked_q;

  assign locked_o = locked_q;
  assign fail_o   = fail_q != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      fail_q   <= '0;
    end else if (settle_i && !hit_i) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      fail_q   <= len_i;
    end else begin
      if (fail_q != '0) fail_q <= fail_q - CNT_W'(1);
      if (settle_i) begin
        if (good_q < GW'(LOCK_LINES)) good_q <= good_q + GW'(1);
        if (good_q >= GW'(LOCK_LINES - 1)) locked_q <= 1'b1;
      end
    end
  end

  // R7: a miss drops lock and raises the fail flag
  a_r7_miss_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settle_i && !hit_i |=> !locked_o && fail_o);
  // R6: lock only rises on a hit
  a_r6_lock_on_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(settle_i && hit_i));
endmodule

// File: rtl/hsync_lock_core.sv
module hsync_lock_core
  import hlock_pkg::*;
#(
  parameter int LOCK_LINES = 4,
  parameter int WINDOW     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hsync_i,
  input  logic [2:0] prog_i,
  input  logic       int_div_i,
  input  logic       ext_div_i,
  input  logic [1:0] mode_i,
  output logic       div_o,
  output logic       pump_up_o,
  output logic       pump_dn_o,
  output logic       pump_en_o,
  output logic       locked_o,
  output logic       lock_fail_o
);
  logic [2:0]       hs_q;
  logic             ext_q;
  logic             hs_rise, ext_rise, wrap, fb, reload, coast;
  logic             up, dn, settle, hit;
  logic [CNT_W-1:0] n_sel, err;
  mode_e            mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= '0;
      ext_q <= 1'b0;
    end else begin
      hs_q  <= {hs_q[1:0], hsync_i};
      ext_q <= ext_div_i;
    end
  end

  assign mode     = mode_e'(mode_i);
  assign coast    = (mode == MODE_COAST) || (mode == MODE_COAST2);
  assign hs_rise  = hs_q[1] & ~hs_q[2];
  assign ext_rise = ext_div_i & ~ext_q;
  assign n_sel    = line_len(prog_i);
  assign reload   = int_div_i && (mode == MODE_FAST) && !locked_o && hs_rise;
  assign fb       = int_div_i ? wrap : ext_rise;
  assign hit      = err <= CNT_W'(WINDOW);

  hlock_line_div u_div (
    .clk_i, .rst_ni, .en_i(int_div_i), .reload_i(reload), .len_i(n_sel), .wrap_o(wrap)
  );

  hlock_pfd u_pfd (
    .clk_i, .rst_ni, .ref_i(hs_rise), .fb_i(fb), .lim_i(n_sel),
    .up_o(up), .dn_o(dn), .settle_o(settle), .err_o(err)
  );

  hlock_lock_track #(.LOCK_LINES(LOCK_LINES)) u_lock (
    .clk_i, .rst_ni, .settle_i(settle), .hit_i(hit), .len_i(n_sel),
    .locked_o(locked_o), .fail_o(lock_fail_o)
  );

  assign div_o     = wrap;
  assign pump_en_o = !coast && !locked_o;
  assign pump_up_o = up & pump_en_o;
  assign pump_dn_o = dn & pump_en_o;

  // R8: no pump drive in coast
  a_r8_coast_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> !pump_en_o && !pump_up_o && !pump_dn_o);
  // R8: no pump drive while locked
  a_r8_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !pump_up_o && !pump_dn_o);
  // R2: bypassed divider is silent
  a_r2_bypass_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_div_i |-> !div_o);
endmodule

// File: tb/hsync_lock_core_test.sv
module hsync_lock_core_test;
  localparam int N = 1364;

  logic       clk, rst_n, hsync, int_div, ext_div;
  logic [2:0] prog;
  logic [1:0] mode;
  logic       div_o, up_o, dn_o, en_o, locked_o, fail_o;

  int checks = 0, errors = 0;
  bit done = 0;
  bit gen_on = 0, ext_on = 0;
  int gen_period = N, gen_extra = 0;
  int up_cnt = 0, dn_cnt = 0, div_cnt = 0;

  hsync_lock_core uut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .prog_i(prog),
    .int_div_i(int_div), .ext_div_i(ext_div), .mode_i(mode),
    .div_o(div_o), .pump_up_o(up_o), .pump_dn_o(dn_o), .pump_en_o(en_o),
    .locked_o(locked_o), .lock_fail_o(fail_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // sync and external feedback generator
  initial begin
    int ph, cur;
    ph = 0; cur = N; hsync = 0; ext_div = 0;
    forever begin
      @(negedge clk);
      if (!gen_on) begin
        hsync = 0; ext_div = 0; ph = 0; cur = gen_period;
      end else begin
        hsync   = ph < 8;
        ext_div = ext_on && ph >= 2 && ph < 6;
        ph++;
        if (ph >= cur) begin
          ph = 0; cur = gen_period + gen_extra; gen_extra = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (up_o) up_cnt++;
    if (dn_o) dn_cnt++;
    if (div_o) div_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cond_lock(input int max, output int seen);
    seen = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (locked_o) begin seen = 1; break; end
    end
  endtask

  task automatic wait_fail(input int max, output int seen);
    seen = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (fail_o) begin seen = 1; break; end
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    up_cnt = 0; dn_cnt = 0; div_cnt = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 locked", locked_o, 0);
    check("R11 lock_fail", fail_o, 0);
    check("R11 pump_up", up_o, 0);
    check("R11 pump_dn", dn_o, 0);
    check("R11 div", div_o, 0);
    check("R11 pump_en", en_o, 1);
  endtask

  task automatic t_divisors();
    int codes[3] = '{4, 0, 3};
    int lens[3]  = '{1364, 1702, 2270};
    foreach (codes[k]) begin
      int len;
      prog = 3'(codes[k]);
      @(negedge clk);
      while (!div_o) @(negedge clk);
      @(negedge clk);
      while (!div_o) @(negedge clk);
      len = 0;
      do begin @(negedge clk); len++; end while (!div_o);
      check("R1 divide period", len, lens[k]);
    end
    prog = 3'b100;
  endtask

  task automatic t_normal_no_lock();
    int seen;
    mode = 2'b00;
    repeat (300) @(negedge clk);
    gen_on = 1;
    wait_cond_lock(8 * N, seen);
    check("R9 normal mode stays unlocked", seen, 0);
  endtask

  task automatic t_fast_lock();
    int seen;
    mode = 2'b01;
    wait_cond_lock(6 * N, seen);
    check("R9 fast lock reached", seen, 1);
    check("R6 locked", locked_o, 1);
    check("R8 pump_en low when locked", en_o, 0);
    check("R7 lock_fail low when locked", fail_o, 0);
  endtask

  task automatic t_slow_sync();
    int seen;
    mode = 2'b00;
    @(posedge clk);
    gen_period = N + 14;
    wait_fail(3 * N, seen);
    check("R7 lock_fail on slow sync", seen, 1);
    check("R7 lock dropped", locked_o, 0);
    clr_mon();
    repeat (3 * N) @(negedge clk);
    check("R5 lower requests seen", dn_cnt > 0, 1);
    check("R5 no raise requests", up_cnt, 0);
    check("R8 pump_en high when unlocked", en_o, 1);
  endtask

  task automatic t_coast();
    mode = 2'b10;
    repeat (2) @(negedge clk);
    clr_mon();
    repeat (2 * N) @(negedge clk);
    check("R8 coast pump_en", en_o, 0);
    check("R8 coast no requests", up_cnt + dn_cnt, 0);
    mode = 2'b11;
    clr_mon();
    repeat (N) @(negedge clk);
    check("R8 alt coast no requests", up_cnt + dn_cnt + int'(en_o), 0);
  endtask

  task automatic t_relock();
    int seen;
    @(posedge clk);
    gen_period = N;
    mode = 2'b01;
    wait_cond_lock(10 * N, seen);
    check("R9 fast relock", seen, 1);
  endtask

  task automatic t_fast_sync();
    int seen;
    mode = 2'b00;
    @(posedge clk);
    gen_period = N - 14;
    wait_fail(3 * N, seen);
    check("R7 lock_fail on fast sync", seen, 1);
    clr_mon();
    repeat (3 * N) @(negedge clk);
    check("R4 raise requests seen", up_cnt > 0, 1);
    check("R4 no lower requests", dn_cnt, 0);
  endtask

  task automatic t_late_line();
    int seen, len;
    @(posedge clk);
    gen_extra = 5;
    wait_fail(3 * N, seen);
    check("R7 late line flagged", seen, 1);
    len = 0;
    while (fail_o && len < 4 * N) begin len++; @(negedge clk); end
    check("R7 fail stretch two misses", len, 2 * N);
    wait_cond_lock(6 * N, seen);
    check("R6 relock after late line", seen, 1);
  endtask

  task automatic t_timeout();
    int seen;
    mode = 2'b00;
    @(posedge clk);
    gen_on = 0;
    wait_fail(3 * N, seen);
    check("R10 missing sync flagged", seen, 1);
    check("R10 lock dropped", locked_o, 0);
  endtask

  task automatic t_external();
    int seen;
    int_div = 0;
    repeat (2 * N) @(negedge clk);
    clr_mon();
    ext_on = 1;
    gen_on = 1;
    wait_cond_lock(8 * N, seen);
    check("R2 lock on external feedback", seen, 1);
    check("R3 lock with wide sync pulse", locked_o, 1);
    check("R2 div quiet when bypassed", div_cnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; prog = 3'b100; int_div = 1; mode = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_divisors();
    t_normal_no_lock();
    t_fast_lock();
    t_slow_sync();
    t_coast();
    t_relock();
    t_fast_sync();
    t_relock();
    t_late_line();
    t_timeout();
    t_external();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule